// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block turns the synchronized levels of a 94-pin GPIO bank into pending-interrupt flags and one combined interrupt line. Each pin picks its own trigger type with two configuration bits, a level/edge choice and a polarity flip. Together they select rising-edge, falling-edge, level-low or level-high detection. A detected event sets the pin's pending flag. A per-pin sense-disable input blocks detection for that pin.

Pending flags and enables are grouped into 32-bit words, one word per 32 pins, and a word index selects which word a write reaches. Software writes ones to pending flags to clear them, normally before it services the event, so a fresh edge that arrives after the clear is captured again. A per-pin enable word gates each pending flag onto the combined interrupt output, which is registered. Bus decode and pad control sit outside this block.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is asserted, every pending flag, every enable bit and the combined interrupt are 0.
- R2: Trigger code {level=0, flip=0} is rising edge: a pin that reads 0 at one clock edge and 1 at the next has its pending flag set after that second edge. A 1-to-0 transition sets nothing.
- R3: Trigger code {level=0, flip=1} is falling edge: a 1-to-0 transition sets the flag, and a 0-to-1 transition does not.
- R4: Trigger code {level=1, flip=0} is level low: the flag is set at every clock edge at which the pin reads 0, so a clear while the pin is low has no lasting effect.
- R5: Trigger code {level=1, flip=1} is level high: the flag is set at every clock edge at which the pin reads 1.
- R6: A pending-flag write with word index w clears every flag of pins 32*w..32*w+31 whose data bit (pin minus 32*w) is 1. Flags whose data bit is 0 keep their value. Index 3 reaches no word.
- R7: When an event and a clearing write hit the same flag at the same edge, the flag ends up set.
- R8: An enable write with word index w loads the enables of pins 32*w..32*w+31 from the data bits. The combined interrupt is the OR over all pins of (flag AND enable), registered one clock after the flags and enables it reflects.
- R9: Pending flags are set whether or not the pin is enabled. With all enables at 0 the combined interrupt stays 0.
- R10: A pin whose sense-disable input is 1 sets no pending flag in any trigger mode.
- R11: No edge event is detected at the first clock edge after reset is released, whatever the pin levels are.
- R12: After a flag is cleared, a new qualifying edge on the same pin sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_lvl_i | input | 94 | Synchronized pin levels |
| trig_lvl_i | input | 94 | Per-pin trigger type: 0 edge, 1 level |
| trig_inv_i | input | 94 | Per-pin polarity flip |
| sense_off_i | input | 94 | Per-pin detection disable |
| sts_wr_en_i | input | 1 | Write strobe for the pending-flag words (write-one-to-clear) |
| sts_wr_sel_i | input | 2 | Word index of the pending-flag write |
| sts_wr_data_i | input | 32 | Clear mask for the selected word |
| en_wr_en_i | input | 1 | Write strobe for the enable words |
| en_wr_sel_i | input | 2 | Word index of the enable write |
| en_wr_data_i | input | 32 | New enable bits for the selected word |
| status_o | output | 94 | Pending flags, one per pin |
| enable_o | output | 94 | Enable bits, one per pin |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
A stale or wrongly reset previous-level register shows up on status_o one clock after the pin changes, as a spurious flag or a missing one, and reaches irq_o one clock later if the pin is enabled. A wrong priority between clear and event shows on status_o at the very edge where both land, so a pin that stays set or drops unexpectedly is visible before the next write. Because the bench model advances on every clock and is compared on every clock, any divergence in flags, enables or the combined line is caught in the cycle it first appears, not only at the scripted checkpoints.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int GPIO_NPIN   = 94;
    localparam int GPIO_WORD_W = 32;

    // {level_select, polarity_flip}
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/gpio_irq_edge_det.sv
module gpio_irq_edge_det
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = GPIO_NPIN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_lvl_i,
    input  logic [NPIN-1:0] trig_lvl_i,
    input  logic [NPIN-1:0] trig_inv_i,
    input  logic [NPIN-1:0] sense_off_i,
    output logic [NPIN-1:0] evt_o
);

    logic [NPIN-1:0] prev_q;
    logic            primed_q;

    // Previous level and a flag that blocks edges in the first cycle after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= pin_lvl_i;
            primed_q <= 1'b1;
        end
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        trig_mode_e mode;
        logic       hit;

        always_comb begin
            mode = trig_mode_e'({trig_lvl_i[p], trig_inv_i[p]});
            unique case (mode)
                TRIG_RISE: hit = primed_q &  pin_lvl_i[p] & ~prev_q[p];
                TRIG_FALL: hit = primed_q & ~pin_lvl_i[p] &  prev_q[p];
                TRIG_LOW:  hit = ~pin_lvl_i[p];
                TRIG_HIGH: hit =  pin_lvl_i[p];
                default:   hit = 1'b0;
            endcase
        end

        assign evt_o[p] = hit & ~sense_off_i[p];
    end

endmodule

// File: rtl/gpio_irq_word_regs.sv
module gpio_irq_word_regs #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] evt_i,
    input  logic              clr_hit_i,
    input  logic [WORD_W-1:0] clr_data_i,
    input  logic              en_hit_i,
    input  logic [WORD_W-1:0] en_data_i,
    output logic [WORD_W-1:0] status_o,
    output logic [WORD_W-1:0] enable_o
);

    logic [WORD_W-1:0] clr_mask;

    assign clr_mask = clr_hit_i ? clr_data_i : '0;

    // Clear first, then events OR in: an event on the same edge wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_o <= '0;
        end else begin
            status_o <= (status_o & ~clr_mask) | evt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_o <= '0;
        end else if (en_hit_i) begin
            enable_o <= en_data_i;
        end
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i))); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit_i |=> ((status_o & $past(clr_data_i & ~evt_i)) == '0)); // R6

    AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(evt_i)) == '0)); // R10

    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en_hit_i |=> (enable_o == $past(en_data_i))); // R8

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
    parameter int NBIT = 96
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBIT-1:0] status_i,
    input  logic [NBIT-1:0] enable_i,
    output logic            irq_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |(status_i & enable_i);
        end
    end

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == (|($past(status_i) & $past(enable_i))))); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable_i) == '0) |-> !irq_o); // R9

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPIN   = GPIO_NPIN,
    parameter int WORD_W = GPIO_WORD_W,
    localparam int NWORD = (NPIN + WORD_W - 1) / WORD_W,
    localparam int SEL_W = (NWORD > 1) ? $clog2(NWORD + 1) : 1,
    localparam int PAD_N = NWORD * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_lvl_i,
    input  logic [NPIN-1:0]   trig_lvl_i,
    input  logic [NPIN-1:0]   trig_inv_i,
    input  logic [NPIN-1:0]   sense_off_i,
    input  logic              sts_wr_en_i,
    input  logic [SEL_W-1:0]  sts_wr_sel_i,
    input  logic [WORD_W-1:0] sts_wr_data_i,
    input  logic              en_wr_en_i,
    input  logic [SEL_W-1:0]  en_wr_sel_i,
    input  logic [WORD_W-1:0] en_wr_data_i,
    output logic [NPIN-1:0]   status_o,
    output logic [NPIN-1:0]   enable_o,
    output logic              irq_o
);

    logic [NPIN-1:0]  evt;
    logic [PAD_N-1:0] evt_pad;
    logic [PAD_N-1:0] status_pad;
    logic [PAD_N-1:0] enable_pad;

    gpio_irq_edge_det #(.NPIN(NPIN)) u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_lvl_i   (pin_lvl_i),
        .trig_lvl_i  (trig_lvl_i),
        .trig_inv_i  (trig_inv_i),
        .sense_off_i (sense_off_i),
        .evt_o       (evt)
    );

    assign evt_pad = {{(PAD_N - NPIN + 1){1'b0}}, evt} [PAD_N-1:0];

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        logic clr_hit;
        logic en_hit;

        assign clr_hit = sts_wr_en_i && (sts_wr_sel_i == SEL_W'(w));
        assign en_hit  = en_wr_en_i  && (en_wr_sel_i  == SEL_W'(w));

        gpio_irq_word_regs #(.WORD_W(WORD_W)) u_word (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt_pad[w*WORD_W +: WORD_W]),
            .clr_hit_i  (clr_hit),
            .clr_data_i (sts_wr_data_i),
            .en_hit_i   (en_hit),
            .en_data_i  (en_wr_data_i),
            .status_o   (status_pad[w*WORD_W +: WORD_W]),
            .enable_o   (enable_pad[w*WORD_W +: WORD_W])
        );
    end

    gpio_irq_combine #(.NBIT(PAD_N)) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_pad),
        .enable_i (enable_pad),
        .irq_o    (irq_o)
    );

    assign status_o = status_pad[NPIN-1:0];
    assign enable_o = enable_pad[NPIN-1:0];

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |-> (status_o == '0 && enable_o == '0 && !irq_o)); // R1

endmodule

// File: tb/gpio_irq_detect_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb_top;

    localparam int NPIN = 94;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NPIN-1:0] pin = '0, tsel = '0, tinv = '0, soff = '0;
    logic            sts_we = 1'b0, en_we = 1'b0;
    logic [1:0]      sts_sel = '0, en_sel = '0;
    logic [31:0]     sts_dat = '0, en_dat = '0;
    logic [NPIN-1:0] status, enable;
    logic            irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_irq_detect dut_i (
        .clk(clk), .rst_n(rst_n), .pin_lvl_i(pin), .trig_lvl_i(tsel),
        .trig_inv_i(tinv), .sense_off_i(soff),
        .sts_wr_en_i(sts_we), .sts_wr_sel_i(sts_sel), .sts_wr_data_i(sts_dat),
        .en_wr_en_i(en_we), .en_wr_sel_i(en_sel), .en_wr_data_i(en_dat),
        .status_o(status), .enable_o(enable), .irq_o(irq)
    );

    // Behavioural reference model
    logic [NPIN-1:0] m_sts, m_en, m_prev;
    logic            m_primed, m_irq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sts <= '0; m_en <= '0; m_prev <= '0; m_primed <= 1'b0; m_irq <= 1'b0;
        end else begin
            bit any;
            any = 0;
            for (int i = 0; i < NPIN; i++) begin
                bit ev;
                bit nxt;
                int w;
                w = i / 32;
                if (tsel[i])          ev = tinv[i] ? pin[i] : !pin[i];
                else if (!m_primed)   ev = 0;
                else if (tinv[i])     ev = m_prev[i] && !pin[i];
                else                  ev = !m_prev[i] && pin[i];
                if (soff[i]) ev = 0;
                nxt = m_sts[i];
                if (sts_we && sts_sel == w && sts_dat[i % 32]) nxt = 0;
                if (ev) nxt = 1;
                m_sts[i]  <= nxt;
                m_prev[i] <= pin[i];
                if (en_we && en_sel == w) m_en[i] <= en_dat[i % 32];
                if (m_sts[i] && m_en[i]) any = 1;
            end
            m_irq    <= any;
            m_primed <= 1'b1;
        end
    end

    task automatic check(input string req, input logic [NPIN-1:0] act, input logic [NPIN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 status vs model", status, m_sts);
            check("R8 enable vs model", enable, m_en);
            check("R8 irq vs model", NPIN'(irq), NPIN'(m_irq));
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sts_write(input logic [1:0] sel, input logic [31:0] dat);
        sts_we = 1'b1; sts_sel = sel; sts_dat = dat;
        tick();
        sts_we = 1'b0; sts_dat = '0;
    endtask

    task automatic en_write(input logic [1:0] sel, input logic [31:0] dat);
        en_we = 1'b1; en_sel = sel; en_dat = dat;
        tick();
        en_we = 1'b0; en_dat = '0;
    endtask

    function automatic logic [NPIN-1:0] b(input int i);
        return NPIN'(1) << i;
    endfunction

    initial begin
        // Configuration: pin 40 falling, pin 70 level low, pin 93 level high, pin 33 sense off
        tsel = b(70) | b(93);
        tinv = b(40) | b(93);
        soff = b(33);
        pin  = b(70) | b(5);
        repeat (3) @(negedge clk);
        check("R1 status in reset", status, '0);
        check("R1 enable in reset", enable, '0);
        check("R1 irq in reset", NPIN'(irq), '0);
        rst_n = 1'b1;
        tick();
        check("R11 no edge after reset", status, '0);
        tick();
        check("R11 still quiet", status, '0);

        pin[0] = 1'b1; tick();
        check("R2 rising sets", status & b(0), b(0));
        sts_write(2'd0, 32'h1);
        check("R6 clear bit0", status & b(0), '0);
        pin[0] = 1'b0; tick();
        check("R2 falling ignored", status & b(0), '0);

        pin[40] = 1'b1; tick();
        check("R3 rising ignored", status & b(40), '0);
        pin[40] = 1'b0; tick();
        check("R3 falling sets", status & b(40), b(40));

        pin[70] = 1'b0; tick();
        check("R4 low sets", status & b(70), b(70));
        sts_write(2'd2, 32'h40);
        check("R4 clear while low holds", status & b(70), b(70));
        pin[70] = 1'b1; tick();
        check("R4 still set after release", status & b(70), b(70));
        sts_write(2'd2, 32'h40);
        check("R4 clear after release", status & b(70), '0);

        pin[93] = 1'b1; tick();
        check("R5 high sets", status & b(93), b(93));
        tick();
        check("R9 masked irq low", NPIN'(irq), '0);

        en_write(2'd2, 32'h2000_0000);
        check("R8 enable loaded", enable, b(93));
        check("R8 irq one cycle later", NPIN'(irq), '0);
        tick();
        check("R8 irq asserted", NPIN'(irq), NPIN'(1));
        pin[93] = 1'b0;
        sts_write(2'd2, 32'h2000_0000);
        check("R8 flag cleared", status & b(93), '0);
        check("R8 irq registered lag", NPIN'(irq), NPIN'(1));
        tick();
        check("R8 irq drops", NPIN'(irq), '0);

        pin[1] = 1'b1;
        sts_write(2'd0, 32'h2);
        check("R7 event beats clear", status & b(1), b(1));

        sts_write(2'd0, 32'h0);
        check("R6 zero write keeps", status & b(1), b(1));
        sts_write(2'd3, 32'hFFFF_FFFF);
        check("R6 index 3 reaches nothing", status & (b(1) | b(40)), b(1) | b(40));
        sts_write(2'd1, 32'hFFFF_FFFF);
        check("R6 full word clear", status & b(40), '0);

        pin[2] = 1'b1; tick();
        check("R12 first edge", status & b(2), b(2));
        sts_write(2'd0, 32'h4);
        check("R12 cleared", status & b(2), '0);
        pin[2] = 1'b0; tick();
        pin[2] = 1'b1; tick();
        check("R12 new edge sets again", status & b(2), b(2));

        pin[33] = 1'b1; tick();
        check("R10 sense off blocks", status & b(33), '0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        checks++;
        done = 1;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule